// File: doc/BRIEF.md
# Cross-Thread Oldest/Youngest Entry Selector

This block sits beside a set of per-thread in-order instruction lists in a multithreaded out-of-order core. Each thread reports whether its list holds anything, the sequence number of its oldest entry, the sequence number of its youngest entry, and whether that oldest entry may commit. The block decides which thread owns the globally oldest entry and which thread owns the globally youngest entry. It also raises a single flag when at least one thread is able to commit. No list storage is needed to keep a shared circular pointer.

A thread takes part only while it is active and its list is non-empty. Threads are examined in ascending ID order. The first eligible thread is taken as the running candidate. A later thread displaces it only with a strictly smaller head number for the oldest pick, or a strictly larger tail number for the youngest pick, so ties go to the lower ID. Sequence numbers are unsigned and are assumed never to wrap. The selection logic is combinational. A parameter chooses whether the results pass through one output register or go straight to the ports.

Top module: `seqpick_top`

## Requirements
- R1: A thread whose `active` bit is 0 or whose `nonempty` bit is 0 is never reported as the oldest or the youngest thread, whatever its sequence numbers.
- R2: When at least one thread is eligible, `old_vld` is 1 and `old_tid` names the eligible thread with the smallest `head_seq` (thread i occupies bits [i*SEQ_W +: SEQ_W]).
- R3: When at least one thread is eligible, `yng_vld` is 1 and `yng_tid` names the eligible thread with the largest `tail_seq` (same packing as R2).
- R4: When no thread is eligible, `old_vld` and `yng_vld` are 0 and both thread IDs read 0.
- R5: When eligible threads tie on the compared number, the lowest thread ID wins, for both the oldest and the youngest pick.
- R6: `commit_ok` is 1 exactly when some thread is active, non-empty and has its `head_ready` bit set; a ready bit on an inactive or empty thread has no effect.
- R7: With `REG_OUT`=1, every output reflects the inputs sampled at the previous rising clock edge, and while `rst_n` is low all outputs are 0.
- R8: The oldest and youngest picks are made independently, so they may name different threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| active | input | NTHR | Per-thread active mask |
| nonempty | input | NTHR | Per-thread list holds at least one entry |
| head_ready | input | NTHR | Per-thread oldest entry may commit |
| head_seq | input | NTHR*SEQ_W | Packed per-thread oldest-entry sequence numbers |
| tail_seq | input | NTHR*SEQ_W | Packed per-thread youngest-entry sequence numbers |
| old_vld | output | 1 | An oldest thread was found |
| old_tid | output | TID_W | Thread holding the globally oldest entry |
| yng_vld | output | 1 | A youngest thread was found |
| yng_tid | output | TID_W | Thread holding the globally youngest entry |
| commit_ok | output | 1 | Some eligible thread has a ready oldest entry |

## Verification
The selection is tried with a single eligible thread, with head numbers in ascending and in descending thread order, and with the oldest and youngest owners on different threads. These cases show whether the comparison really picks the minimum and maximum rather than the first or the last thread scanned. Equal numbers across threads show whether ties go to the lower ID. Inactive or empty threads carrying the smallest head number or a ready bit show that the eligibility mask is applied before comparison and before the commit reduction. A sweep of pseudo-random patterns against a bench model, plus a check just before the clock edge, covers the general case and the one-cycle register latency.

// File: rtl/seqpick_pkg.sv
package seqpick_pkg;

    function automatic int tid_width(input int nthr);
        return (nthr > 1) ? $clog2(nthr) : 1;
    endfunction

endpackage

// File: rtl/seqpick_scan.sv
module seqpick_scan #(
    parameter int NTHR     = 4,
    parameter int SEQ_W    = 32,
    parameter int TID_W    = 2,
    parameter bit PICK_MAX = 1'b0
) (
    input  logic [NTHR-1:0]       elig,
    input  logic [NTHR*SEQ_W-1:0] seq,
    output logic                  vld,
    output logic [TID_W-1:0]      tid
);

    logic [SEQ_W-1:0] best;
    logic [NTHR-1:0]  beats;

    // Strict comparison per thread against the running candidate is
    // resolved inside the scan; the variant chooses the direction.
    always_comb begin
        vld   = 1'b0;
        tid   = '0;
        best  = '0;
        beats = '0;
        for (int i = 0; i < NTHR; i++) begin
            if (PICK_MAX) beats[i] = seq[i*SEQ_W +: SEQ_W] > best;
            else          beats[i] = seq[i*SEQ_W +: SEQ_W] < best;
            if (elig[i] && (!vld || beats[i])) begin
                vld  = 1'b1;
                tid  = TID_W'(i);
                best = seq[i*SEQ_W +: SEQ_W];
            end
        end
    end

endmodule

// File: rtl/seqpick_commit.sv
module seqpick_commit #(
    parameter int NTHR = 4
) (
    input  logic [NTHR-1:0] elig,
    input  logic [NTHR-1:0] head_ready,
    output logic            commit_ok
);

    assign commit_ok = |(elig & head_ready);

endmodule

// File: rtl/seqpick_top.sv
module seqpick_top #(
    parameter int NTHR    = 4,
    parameter int SEQ_W   = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int TID_W  = seqpick_pkg::tid_width(NTHR)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTHR-1:0]       active,
    input  logic [NTHR-1:0]       nonempty,
    input  logic [NTHR-1:0]       head_ready,
    input  logic [NTHR*SEQ_W-1:0] head_seq,
    input  logic [NTHR*SEQ_W-1:0] tail_seq,
    output logic                  old_vld,
    output logic [TID_W-1:0]      old_tid,
    output logic                  yng_vld,
    output logic [TID_W-1:0]      yng_tid,
    output logic                  commit_ok
);

    typedef struct packed {
        logic             old_vld;
        logic [TID_W-1:0] old_tid;
        logic             yng_vld;
        logic [TID_W-1:0] yng_tid;
        logic             commit_ok;
    } sel_t;

    logic [NTHR-1:0]  elig;
    logic             o_vld_c, y_vld_c, cm_c;
    logic [TID_W-1:0] o_tid_c, y_tid_c;
    sel_t             sel_d, sel_q;

    assign elig = active & nonempty;

    seqpick_scan #(.NTHR(NTHR), .SEQ_W(SEQ_W), .TID_W(TID_W), .PICK_MAX(1'b0)) u_old (
        .elig(elig), .seq(head_seq), .vld(o_vld_c), .tid(o_tid_c)
    );

    seqpick_scan #(.NTHR(NTHR), .SEQ_W(SEQ_W), .TID_W(TID_W), .PICK_MAX(1'b1)) u_yng (
        .elig(elig), .seq(tail_seq), .vld(y_vld_c), .tid(y_tid_c)
    );

    seqpick_commit #(.NTHR(NTHR)) u_cm (
        .elig(elig), .head_ready(head_ready), .commit_ok(cm_c)
    );

    always_comb begin
        sel_d           = '0;
        sel_d.old_vld   = o_vld_c;
        sel_d.old_tid   = o_tid_c;
        sel_d.yng_vld   = y_vld_c;
        sel_d.yng_tid   = y_tid_c;
        sel_d.commit_ok = cm_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    sel_t sel_o;
    generate
        if (REG_OUT) begin : g_reg
            assign sel_o = sel_q;
        end else begin : g_comb
            assign sel_o = sel_d;
        end
    endgenerate

    assign old_vld   = sel_o.old_vld;
    assign old_tid   = sel_o.old_tid;
    assign yng_vld   = sel_o.yng_vld;
    assign yng_tid   = sel_o.yng_tid;
    assign commit_ok = sel_o.commit_ok;

    // Assertions on the scan results against the raw inputs
    a_r1_old_elig: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld_c |-> (active[o_tid_c] && nonempty[o_tid_c]));
    a_r1_yng_elig: assert property (@(posedge clk) disable iff (!rst_n)
        y_vld_c |-> (active[y_tid_c] && nonempty[y_tid_c]));
    a_r4_none_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        ((active & nonempty) == '0) |-> (!o_vld_c && !y_vld_c));
    a_r6_commit_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        cm_c |-> o_vld_c);
    a_r7_reg_follows: assert property (@(posedge clk) disable iff (!rst_n)
        REG_OUT |=> (old_vld == $past(o_vld_c) && yng_vld == $past(y_vld_c)));

    generate
        for (genvar g = 0; g < NTHR; g++) begin : g_chk
            a_r2_old_min: assert property (@(posedge clk) disable iff (!rst_n)
                (o_vld_c && elig[g]) |->
                (head_seq[g*SEQ_W +: SEQ_W] >= head_seq[o_tid_c*SEQ_W +: SEQ_W]));
            a_r3_yng_max: assert property (@(posedge clk) disable iff (!rst_n)
                (y_vld_c && elig[g]) |->
                (tail_seq[g*SEQ_W +: SEQ_W] <= tail_seq[y_tid_c*SEQ_W +: SEQ_W]));
        end
    endgenerate

endmodule

// File: tb/seqpick_top_bench.sv
`timescale 1ns/1ps
module seqpick_top_bench;

    localparam int NTHR  = 4;
    localparam int SEQ_W = 32;
    localparam int TID_W = 2;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [NTHR-1:0]       active, nonempty, head_ready;
    logic [NTHR*SEQ_W-1:0] head_seq, tail_seq;
    logic                  old_vld, yng_vld, commit_ok;
    logic [TID_W-1:0]      old_tid, yng_tid;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    seqpick_top #(.NTHR(NTHR), .SEQ_W(SEQ_W), .REG_OUT(1'b1)) u_seqpick_top (
        .clk(clk), .rst_n(rst_n), .active(active), .nonempty(nonempty),
        .head_ready(head_ready), .head_seq(head_seq), .tail_seq(tail_seq),
        .old_vld(old_vld), .old_tid(old_tid), .yng_vld(yng_vld),
        .yng_tid(yng_tid), .commit_ok(commit_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench model written from the requirements
    task automatic expect_all(input string req);
        logic ov, yv, cm;
        int ot, yt;
        logic [SEQ_W-1:0] hb, tb, h, t;
        ov = 0; yv = 0; cm = 0; ot = 0; yt = 0; hb = 0; tb = 0;
        for (int i = 0; i < NTHR; i++) begin
            h = head_seq[i*SEQ_W +: SEQ_W];
            t = tail_seq[i*SEQ_W +: SEQ_W];
            if (active[i] && nonempty[i]) begin
                if (!ov || h < hb) begin ov = 1; ot = i; hb = h; end
                if (!yv || t > tb) begin yv = 1; yt = i; tb = t; end
                if (head_ready[i]) cm = 1;
            end
        end
        chk({req, " old_vld"}, int'(old_vld), int'(ov));
        chk({req, " old_tid"}, int'(old_tid), ot);
        chk({req, " yng_vld"}, int'(yng_vld), int'(yv));
        chk({req, " yng_tid"}, int'(yng_tid), yt);
        chk({req, " commit_ok"}, int'(commit_ok), int'(cm));
    endtask

    task automatic drive(input logic [3:0] a, input logic [3:0] n, input logic [3:0] r,
                         input int h0, input int h1, input int h2, input int h3,
                         input int t0, input int t1, input int t2, input int t3);
        @(negedge clk);
        active = a; nonempty = n; head_ready = r;
        head_seq = {h3[31:0], h2[31:0], h1[31:0], h0[31:0]};
        tail_seq = {t3[31:0], t2[31:0], t1[31:0], t0[31:0]};
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        active = '1; nonempty = '1; head_ready = '1;
        head_seq = '1; tail_seq = '1;
        repeat (3) @(posedge clk);
        #2;
        chk("R7 reset old_vld", int'(old_vld), 0);
        chk("R7 reset yng_vld", int'(yng_vld), 0);
        chk("R7 reset commit_ok", int'(commit_ok), 0);
        chk("R7 reset old_tid", int'(old_tid), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_single();
        drive(4'b0100, 4'b0100, 4'b0100, 50, 1, 2, 3, 60, 99, 98, 97);
        chk("R2 single old", int'(old_tid), 2);
        chk("R3 single yng", int'(yng_tid), 2);
        expect_all("R2");
    endtask

    task automatic t_orders();
        drive(4'hF, 4'hF, 4'h0, 10, 20, 30, 40, 15, 25, 35, 45);
        chk("R2 ascending old", int'(old_tid), 0);
        chk("R3 ascending yng", int'(yng_tid), 3);
        drive(4'hF, 4'hF, 4'h0, 40, 30, 20, 10, 45, 35, 25, 15);
        chk("R2 descending old", int'(old_tid), 3);
        chk("R3 descending yng", int'(yng_tid), 0);
        drive(4'hF, 4'hF, 4'h0, 30, 12, 50, 40, 300, 120, 500, 900);
        chk("R8 different owners old", int'(old_tid), 1);
        chk("R8 different owners yng", int'(yng_tid), 3);
        expect_all("R8");
    endtask

    task automatic t_ties();
        drive(4'b1110, 4'hF, 4'h0, 1, 7, 9, 7, 2, 80, 80, 80);
        chk("R5 tie old", int'(old_tid), 1);
        chk("R5 tie yng", int'(yng_tid), 1);
    endtask

    task automatic t_inelig();
        drive(4'b1101, 4'b0111, 4'b1000, 5, 1, 9, 0, 6, 999, 10, 999);
        chk("R1 inactive low head skipped", int'(old_tid), 0);
        chk("R1 inactive high tail skipped", int'(yng_tid), 2);
        chk("R6 ready on empty ignored", int'(commit_ok), 0);
        drive(4'b1011, 4'b1110, 4'b0101, 3, 4, 5, 6, 3, 4, 5, 6);
        chk("R6 ready on inactive/empty ignored", int'(commit_ok), 0);
        drive(4'b1011, 4'b1110, 4'b1000, 3, 4, 5, 6, 3, 4, 5, 6);
        chk("R6 eligible ready commits", int'(commit_ok), 1);
    endtask

    task automatic t_empty();
        drive(4'hF, 4'h0, 4'hF, 1, 2, 3, 4, 1, 2, 3, 4);
        chk("R4 empty old_vld", int'(old_vld), 0);
        chk("R4 empty yng_vld", int'(yng_vld), 0);
        chk("R4 empty old_tid", int'(old_tid), 0);
        chk("R4 empty yng_tid", int'(yng_tid), 0);
    endtask

    task automatic t_latency();
        drive(4'hF, 4'hF, 4'h0, 10, 20, 30, 40, 15, 25, 35, 45);
        @(negedge clk);
        head_seq[3*SEQ_W +: SEQ_W] = 32'd1;
        #1;
        chk("R7 old value held before edge", int'(old_tid), 0);
        @(posedge clk);
        #2;
        chk("R7 new value after edge", int'(old_tid), 3);
    endtask

    task automatic t_sweep();
        logic [31:0] lf = 32'hACE1_2345;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            active = lf[3:0]; nonempty = lf[7:4]; head_ready = lf[11:8];
            for (int i = 0; i < NTHR; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                head_seq[i*SEQ_W +: SEQ_W] = {28'd0, lf[3:0]};
                tail_seq[i*SEQ_W +: SEQ_W] = {28'd0, lf[7:4]} + 32'd20;
            end
            @(posedge clk);
            #2;
            expect_all("R1/R2/R3/R5/R6 sweep");
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_single();
                t_orders();
                t_ties();
                t_inelig();
                t_empty();
                t_latency();
                t_sweep();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule